// File: doc/BRIEF.md
# UART Receive Error Status and Interrupt Controller

This block sits beside a UART's receive and transmit shifters and owns three things: whether the receiver is enabled, a set of sticky receive error flags (parity, framing, overrun), and three interrupt lines (transmit, receive, error). The shifters and FIFOs are elsewhere. They report to this block through single-cycle event pulses: a character finished, a parity or framing fault, an overrun, a transmit completion, and a transmit buffer event.

Software reaches the block through one write port that selects one of four registers. The control register arms the individual error checks. The command register is write-only and holds set and clear strobes: it is the only way to change the receiver enable or to drop an error flag. The interrupt enable register arms the sources. The interrupt clear register is write-one-to-clear. A read-only state word reports the receiver enable and the three flags at fixed bit positions.

Top module: `uart_err_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the state word is zero and all three interrupt lines are low.
- R2: A command write with bit 1 set sets the receiver enable, and with bit 0 set clears it. The enable is reported at state bit 0. When both bits are written together, set wins.
- R3: With the receiver enabled, a parity pulse sets state bit 16 if control bit 20 is set. A framing pulse sets state bit 17 if control bit 17 is set. An overrun pulse sets state bit 19 if control bit 19 is set. Each flag is visible in the cycle after the pulse.
- R4: An error pulse has no effect on the state word while its control check bit is clear or while the receiver is disabled.
- R5: Error flags are sticky. Command bit 2 clears parity, bit 3 clears framing and bit 5 clears overrun, and no other command bit clears a flag. An error event in the same cycle as its clear leaves the flag set.
- R6: An overrun pulse with no character sets the overrun flag but does not raise the receive interrupt. A character that arrives with an overrun still raises the receive interrupt.
- R7: A character pulse raises the receive interrupt only when the receiver is enabled and interrupt enable bit 1 is set. Characters that arrive while the receiver is disabled are dropped.
- R8: The transmit interrupt rises after a transmit-done pulse when interrupt enable bit 0 is set, or after a transmit-buffer pulse when interrupt enable bit 3 is set.
- R9: Writing 1 to interrupt clear bit 0, 1 or 2 clears the pending transmit, receive or error interrupt. A source pulse in the same cycle keeps it pending. Writing a zero bit has no effect.
- R10: The error interrupt is high only while it is pending, interrupt enable bit 2 is set, and at least one error flag is set. It becomes pending when an accepted error event occurs while bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 command, 2 interrupt enable, 3 interrupt clear |
| reg_wdata | input | 32 | Write data |
| rx_char_p | input | 1 | Character received pulse |
| rx_par_err_p | input | 1 | Parity fault pulse |
| rx_frm_err_p | input | 1 | Framing fault pulse |
| rx_ovr_p | input | 1 | Overrun pulse |
| tx_done_p | input | 1 | Transmit done pulse |
| tx_buf_p | input | 1 | Transmit buffer event pulse |
| state_q | output | 32 | State word: bit 0 receiver enable, bits 16/17/19 parity/framing/overrun |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
A flag or pending bit can be set by a receiver pulse and cleared by a software write in the same cycle. The bench provokes this on purpose: it issues a parity clear alongside a parity pulse, and an interrupt-clear write alongside a character pulse. It expects the flag and the pending bit to stay high. Random traffic that mixes writes to all four registers with all six pulse inputs produces many more such collisions. Each one is judged against a bench model built from the set-wins rule.

// File: rtl/usc_pkg.sv
// Shared register selects and field positions for the UART error/interrupt block.
// Assumes a 32-bit register word.
package usc_pkg;
    localparam int unsigned REG_W = 32;
    localparam int unsigned N_ERR = 3;   // parity, framing, overrun
    localparam int unsigned N_IRQ = 3;   // tx, rx, err

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_ICR  = 2'd3
    } reg_sel_e;

    // state word
    localparam int unsigned ST_REN = 0;
    localparam int unsigned ST_PAR = 16;
    localparam int unsigned ST_FRM = 17;
    localparam int unsigned ST_OVR = 19;
    // command word
    localparam int unsigned CMD_CLR_REN = 0;
    localparam int unsigned CMD_SET_REN = 1;
    localparam int unsigned CMD_CLR_PAR = 2;
    localparam int unsigned CMD_CLR_FRM = 3;
    localparam int unsigned CMD_CLR_OVR = 5;
    // control word
    localparam int unsigned CTL_FRM_CHK = 17;
    localparam int unsigned CTL_OVR_CHK = 19;
    localparam int unsigned CTL_PAR_CHK = 20;
    // interrupt enable / clear
    localparam int unsigned IRQ_TX  = 0;
    localparam int unsigned IRQ_RX  = 1;
    localparam int unsigned IRQ_ERR = 2;
    localparam int unsigned IEN_TXB = 3;
    localparam int unsigned IEN_W   = 4;
endpackage

// File: rtl/usc_sticky.sv
// Bank of sticky bits: each bit is set by its set input and cleared by its
// clear input, with set taking priority. Assumes single-cycle strobes.
module usc_sticky #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // hold, set (wins) or clear one bit
        always_ff @(posedge clk) begin
            if (!rst_n)         q_o[i] <= 1'b0;
            else if (set_i[i])  q_o[i] <= 1'b1;
            else if (clr_i[i])  q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/usc_wr_decode.sv
// Decodes the register write port: holds the control check enables and the
// interrupt enables, and turns command and interrupt-clear writes into
// single-cycle strobes. Assumes one write per cycle at most.
module usc_wr_decode
    import usc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [1:0]       sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [N_ERR-1:0] chk_en_o,     // parity, framing, overrun
    output logic [IEN_W-1:0] ien_o,
    output logic             set_ren_o,
    output logic             clr_ren_o,
    output logic [N_ERR-1:0] clr_err_o,
    output logic [N_IRQ-1:0] clr_irq_o
);
    reg_sel_e sel;
    logic     wr_ctrl, wr_cmd, wr_ien, wr_icr;
    logic     unused_bits;

    // decode which register is written this cycle
    always_comb begin
        sel     = reg_sel_e'(sel_i);
        wr_ctrl = we_i && (sel == SEL_CTRL);
        wr_cmd  = we_i && (sel == SEL_CMD);
        wr_ien  = we_i && (sel == SEL_IEN);
        wr_icr  = we_i && (sel == SEL_ICR);
    end

    // hold control check enables and interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_en_o <= '0;
            ien_o    <= '0;
        end else begin
            if (wr_ctrl)
                chk_en_o <= {wdata_i[CTL_OVR_CHK], wdata_i[CTL_FRM_CHK], wdata_i[CTL_PAR_CHK]};
            if (wr_ien)
                ien_o <= wdata_i[IEN_W-1:0];
        end
    end

    // command and interrupt-clear strobes, valid in the write cycle
    always_comb begin
        set_ren_o = wr_cmd && wdata_i[CMD_SET_REN];
        clr_ren_o = wr_cmd && wdata_i[CMD_CLR_REN];
        clr_err_o = wr_cmd ? {wdata_i[CMD_CLR_OVR], wdata_i[CMD_CLR_FRM], wdata_i[CMD_CLR_PAR]}
                           : '0;
        clr_irq_o = wr_icr ? wdata_i[N_IRQ-1:0] : '0;
    end

    assign unused_bits = ^{wdata_i[REG_W-1:CTL_PAR_CHK+1], wdata_i[CTL_OVR_CHK-1],
                           wdata_i[CTL_FRM_CHK-1:CMD_CLR_OVR+1], wdata_i[CMD_CLR_OVR-1]};
endmodule

// File: rtl/uart_err_irq_ctrl.sv
// UART receive error status and interrupt controller (top).
// Keeps the receiver enable, sticky parity/framing/overrun flags and three
// interrupt lines. Receiver and transmitter events arrive as one-cycle pulses.
// Assumes pulses and writes are synchronous to clk.
module uart_err_irq_ctrl
    import usc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             rx_char_p,
    input  logic             rx_par_err_p,
    input  logic             rx_frm_err_p,
    input  logic             rx_ovr_p,
    input  logic             tx_done_p,
    input  logic             tx_buf_p,
    output logic [REG_W-1:0] state_q,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_err
);
    logic [N_ERR-1:0] chk_en, clr_err, err_ev, err_flag;
    logic [IEN_W-1:0] ien;
    logic [N_IRQ-1:0] clr_irq, pend_set, pend;
    logic             set_ren, clr_ren, rx_en;

    usc_wr_decode i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we),
        .sel_i     (reg_sel),
        .wdata_i   (reg_wdata),
        .chk_en_o  (chk_en),
        .ien_o     (ien),
        .set_ren_o (set_ren),
        .clr_ren_o (clr_ren),
        .clr_err_o (clr_err),
        .clr_irq_o (clr_irq)
    );

    // receiver enable: set strobe wins over clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_en <= 1'b0;
        else if (set_ren) rx_en <= 1'b1;
        else if (clr_ren) rx_en <= 1'b0;
    end

    // accepted error events: armed check and enabled receiver
    always_comb begin
        err_ev = {rx_ovr_p, rx_frm_err_p, rx_par_err_p} & chk_en & {N_ERR{rx_en}};
    end

    usc_sticky #(.N(N_ERR)) i_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_ev),
        .clr_i (clr_err),
        .q_o   (err_flag)
    );

    // interrupt pending sources
    always_comb begin
        pend_set[IRQ_TX]  = (tx_done_p && ien[IRQ_TX]) || (tx_buf_p && ien[IEN_TXB]);
        pend_set[IRQ_RX]  = rx_char_p && rx_en && ien[IRQ_RX];
        pend_set[IRQ_ERR] = (|err_ev) && ien[IRQ_ERR];
    end

    usc_sticky #(.N(N_IRQ)) i_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (pend_set),
        .clr_i (clr_irq),
        .q_o   (pend)
    );

    // state word assembly and interrupt outputs
    always_comb begin
        state_q         = '0;
        state_q[ST_REN] = rx_en;
        state_q[ST_PAR] = err_flag[0];
        state_q[ST_FRM] = err_flag[1];
        state_q[ST_OVR] = err_flag[2];
        irq_tx          = pend[IRQ_TX];
        irq_rx          = pend[IRQ_RX];
        irq_err         = pend[IRQ_ERR] && ien[IRQ_ERR] && (|err_flag);
    end
endmodule

// File: rtl/usc_err_irq_sva.sv
// Checker for uart_err_irq_ctrl: port-level temporal properties.
module usc_err_irq_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic        rx_char_p,
    input logic [31:0] state_q,
    input logic        irq_rx,
    input logic        irq_err
);
    logic cmd_wr, icr_wr;
    assign cmd_wr = reg_we && (reg_sel == 2'd1);
    assign icr_wr = reg_we && (reg_sel == 2'd3);

    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && reg_wdata[1] |=> state_q[0]);
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && reg_wdata[0] && !reg_wdata[1] |=> !state_q[0]);
    a_r4_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q[0] && !state_q[16] |=> !state_q[16]);
    a_r5_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_q[16] && !(cmd_wr && reg_wdata[2]) |=> state_q[16]);
    a_r7_drop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q[0] && !irq_rx |=> !irq_rx);
    a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        icr_wr && reg_wdata[1] && !rx_char_p |=> !irq_rx);
    a_r10_err_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (state_q[16] || state_q[17] || state_q[19]));
endmodule

bind uart_err_irq_ctrl usc_err_irq_sva i_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .rx_char_p (rx_char_p),
    .state_q   (state_q),
    .irq_rx    (irq_rx),
    .irq_err   (irq_err)
);

// File: tb/test_uart_err_irq_ctrl.sv
module test_uart_err_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [31:0] wdata = '0;
    logic        p_char = 1'b0, p_par = 1'b0, p_frm = 1'b0, p_ovr = 1'b0, p_txd = 1'b0, p_txb = 1'b0;
    logic [31:0] state_q;
    logic        irq_tx, irq_rx, irq_err;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    // bench model
    logic       m_ren;
    logic [2:0] m_chk;    // parity, framing, overrun
    logic [3:0] m_ien;
    logic [2:0] m_flag;
    logic [2:0] m_pend;   // tx, rx, err

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_err_irq_ctrl i_uart_err_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_sel(sel), .reg_wdata(wdata),
        .rx_char_p(p_char), .rx_par_err_p(p_par), .rx_frm_err_p(p_frm), .rx_ovr_p(p_ovr),
        .tx_done_p(p_txd), .tx_buf_p(p_txb),
        .state_q(state_q), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    function automatic logic [31:0] exp_state();
        logic [31:0] s = '0;
        s[0] = m_ren; s[16] = m_flag[0]; s[17] = m_flag[1]; s[19] = m_flag[2];
        return s;
    endfunction

    function automatic logic exp_err_irq();
        return m_pend[2] & m_ien[2] & (|m_flag);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // model update for one clock edge, from the driven inputs
    task automatic model_edge();
        logic [2:0] ev, clr_e, pset, clr_i;
        logic wc, wm, wi, wk;
        if (!rst_n) begin
            m_ren = 0; m_chk = 0; m_ien = 0; m_flag = 0; m_pend = 0;
            return;
        end
        wc = we && sel == 2'd0; wm = we && sel == 2'd1;
        wi = we && sel == 2'd2; wk = we && sel == 2'd3;
        ev    = {p_ovr, p_frm, p_par} & m_chk & {3{m_ren}};
        clr_e = wm ? {wdata[5], wdata[3], wdata[2]} : 3'b0;
        clr_i = wk ? wdata[2:0] : 3'b0;
        pset[0] = (p_txd & m_ien[0]) | (p_txb & m_ien[3]);
        pset[1] = p_char & m_ren & m_ien[1];
        pset[2] = (|ev) & m_ien[2];
        m_flag = ev | (m_flag & ~clr_e);
        m_pend = pset | (m_pend & ~clr_i);
        if (wm && wdata[1])      m_ren = 1;
        else if (wm && wdata[0]) m_ren = 0;
        if (wc) m_chk = {wdata[19], wdata[17], wdata[20]};
        if (wi) m_ien = wdata[3:0];
    endtask

    // one cycle: inputs were set at a negedge; update at posedge, compare at next negedge
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "state", state_q, exp_state());
        chk(tag, "irq_tx", {31'b0, irq_tx}, {31'b0, m_pend[0]});
        chk(tag, "irq_rx", {31'b0, irq_rx}, {31'b0, m_pend[1]});
        chk(tag, "irq_err", {31'b0, irq_err}, {31'b0, exp_err_irq()});
        we = 0; p_char = 0; p_par = 0; p_frm = 0; p_ovr = 0; p_txd = 0; p_txb = 0;
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        we = 1; sel = s; wdata = d;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ren = 0; m_chk = 0; m_ien = 0; m_flag = 0; m_pend = 0;
        @(negedge clk); step("R1"); step("R1");
        rst_n = 1;
        @(negedge clk);
        chk("R1", "state", state_q, 32'h0);
        chk("R1", "irqs", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);

        // R2: enable, set+clear together, clear
        wr(2'd1, 32'h2); step("R2");
        chk("R2", "ren set", {31'b0, state_q[0]}, 32'h1);
        wr(2'd1, 32'h3); step("R2");
        chk("R2", "set wins", {31'b0, state_q[0]}, 32'h1);
        wr(2'd1, 32'h1); step("R2");
        chk("R2", "ren clear", {31'b0, state_q[0]}, 32'h0);
        // R4: receiver off drops errors even when armed
        wr(2'd0, 32'h001A_0000); step("R4");
        p_par = 1; p_frm = 1; p_ovr = 1; step("R4");
        chk("R4", "rx off", state_q, 32'h0);
        wr(2'd1, 32'h2); step("R2");
        // R4: check disabled
        wr(2'd0, 32'h0); step("R4");
        p_par = 1; p_frm = 1; p_ovr = 1; step("R4");
        chk("R4", "check off", state_q, 32'h1);
        // R3: armed flags
        wr(2'd0, 32'h001A_0000); step("R3");
        p_par = 1; step("R3");
        chk("R3", "parity", state_q, 32'h0001_0001);
        p_frm = 1; step("R3");
        chk("R3", "framing", state_q, 32'h0003_0001);
        // R6: overrun alone, no rx irq even with ien
        wr(2'd2, 32'hF); step("R6");
        p_ovr = 1; step("R6");
        chk("R6", "overrun flag", state_q, 32'h000B_0001);
        chk("R6", "no rx irq", {31'b0, irq_rx}, 32'h0);
        p_ovr = 1; p_char = 1; step("R6");
        chk("R6", "char with overrun", {31'b0, irq_rx}, 32'h1);
        // R5: non-clear bits do not clear; framing clear only
        wr(2'd1, 32'hFFFF_FFD2 & ~32'h2C); step("R5");
        chk("R5", "other bits", state_q & 32'h000B_0000, 32'h000B_0000);
        wr(2'd1, 32'h8); step("R5");
        chk("R5", "framing clear", state_q, 32'h0009_0001);
        wr(2'd1, 32'h4); p_par = 1; step("R5");
        chk("R5", "set beats clear", state_q, 32'h0009_0001);
        // R10: error irq pending and flags present
        chk("R10", "err irq on", {31'b0, irq_err}, 32'h1);
        wr(2'd1, 32'h2C); step("R10");
        chk("R10", "err irq off w/o flags", {31'b0, irq_err}, 32'h0);
        // R9: zero write no effect, clear rx, clear with same-cycle pulse
        wr(2'd3, 32'h0); step("R9");
        chk("R9", "zero write", {31'b0, irq_rx}, 32'h1);
        wr(2'd3, 32'h2); p_char = 1; step("R9");
        chk("R9", "pulse wins", {31'b0, irq_rx}, 32'h1);
        wr(2'd3, 32'h7); step("R9");
        chk("R9", "clear all", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);
        // R7: drop while disabled
        wr(2'd1, 32'h1); step("R7");
        p_char = 1; step("R7");
        chk("R7", "dropped", {31'b0, irq_rx}, 32'h0);
        // R8: transmit sources
        wr(2'd2, 32'h8); step("R8");
        p_txd = 1; step("R8");
        chk("R8", "done masked", {31'b0, irq_tx}, 32'h0);
        p_txb = 1; step("R8");
        chk("R8", "buffer event", {31'b0, irq_tx}, 32'h1);
        wr(2'd3, 32'h1); step("R9");
        chk("R9", "tx clear", {31'b0, irq_tx}, 32'h0);
        wr(2'd2, 32'h1); step("R8");
        p_txd = 1; step("R8");
        chk("R8", "done", {31'b0, irq_tx}, 32'h1);

        // random traffic, R3 R5 R7 R8 R9 R10 all judged by the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                logic [1:0] s = 2'($urandom_range(0, 3));
                logic [31:0] d = $urandom;
                if (s == 2'd1 && $urandom_range(0, 1) == 1) d = d & 32'h2E;
                wr(s, d);
            end
            p_char = ($urandom_range(0, 3) == 0);
            p_par  = ($urandom_range(0, 5) == 0);
            p_frm  = ($urandom_range(0, 5) == 0);
            p_ovr  = ($urandom_range(0, 7) == 0);
            p_txd  = ($urandom_range(0, 4) == 0);
            p_txb  = ($urandom_range(0, 4) == 0);
            step("random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule